// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block sends one character at a time on a single serial line. A write strobe carries a data byte into the block. If the block is idle, the write starts a frame. The frame holds a low start bit, then the data bits LSB first, then an optional extra bit, then one or two high stop bits. The line idles high.

The frame shape comes from an 8-bit mode word and is read only when a frame starts. The mode word sets:
- a 7-bit option that never sends the top data bit,
- parity on or off, with even or odd sense,
- the number of stop bits,
- a multiprocessor format, which sends a flag bit from its own input in the parity position,
- a four-way clock prescaler.

A bit lasts 16 prescaled ticks times (divisor + 1), where the divisor is an 8-bit input. The busy output tells the host when the next character can be written.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `tx_o` is 1 and `busy_o` is 0. A reset during a frame ends the frame at once.
- R2: A write (`wr_i`=1) while `busy_o`=0 starts a frame at that clock edge: `busy_o` rises and `tx_o` drives a low start bit for one bit time.
- R3: Data bits go out LSB first. When mode bit 6 is 0, eight bits are sent. When mode bit 6 is 1, only bits 6..0 are sent and bit 7 of the byte is never sent.
- R4: When mode bit 5 is 1 and mode bit 2 is 0, a parity bit follows the data bits. When mode bit 4 is 0, the data bits sent plus the parity bit hold an even number of ones. When mode bit 4 is 1, they hold an odd number of ones.
- R5: One high stop bit (mode bit 3 = 0) or two (mode bit 3 = 1) ends the frame. `busy_o` falls and `tx_o` stays 1 at the end of the last stop bit.
- R6: When mode bit 2 is 1, no parity bit is sent whatever bit 5 holds. The value of `mpb_i` goes out as one bit between the data bits and the stop bits.
- R7: Mode bits 1:0 select a prescale of 1, 4, 16 or 64 system clocks per tick (codes 0, 1, 2, 3). Each frame bit lasts prescale × 16 × (`div_i`+1) clocks.
- R8: `mode_i`, `div_i`, `wdata_i` and `mpb_i` are captured when a frame starts. Changes to them during a frame do not alter that frame.
- R9: A write while `busy_o`=1 is ignored. The frame in progress continues unchanged.
- R10: Mode bit 7 has no effect. The frame is always asynchronous, with the same shape and timing as with bit 7 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Frame mode word (bit 7 sync select, 6 length, 5 parity on, 4 odd, 3 two stops, 2 multiprocessor, 1:0 prescale) |
| div_i | input | 8 | Bit-rate divisor; a bit lasts 16 × (div_i+1) ticks |
| wr_i | input | 1 | Write strobe for a new character |
| wdata_i | input | 8 | Character to send |
| mpb_i | input | 1 | Multiprocessor flag bit value |
| busy_o | output | 1 | High while a frame is being sent |
| tx_o | output | 1 | Serial line output, idles high |

## Verification
The assertions check the following on every cycle:
- the line is high whenever the block is idle;
- a start is always followed by a low start bit;
- the captured frame settings never move while busy;
- the prescale and bit counters stay within their limits;
- the line changes only at a start or at a bit boundary.

Some behaviour only the bench can show: the exact order of data bits, the parity value, the frame length for each mode, and the bit width for each prescale code. The bench samples every bit in the middle of its slot and checks it against a frame built from the requirements. It also changes the inputs and writes again partway through a frame, and it resets the block mid-frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Field order matches the mode word bit positions (MSB first).
  typedef struct packed {
    logic       sync_sel;
    logic       len7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       mp_en;
    logic [1:0] cks;
  } tx_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/uart_tx_prescaler.sv
module uart_tx_prescaler #(
  parameter int CKS_W    = 2,
  parameter int PRE_LOG2 = 2,
  localparam int NUM_SEL = 2 ** CKS_W,
  localparam int PRE_W   = PRE_LOG2 * (NUM_SEL - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] lim [NUM_SEL];
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim[g] = PRE_W'((64'd1 << (PRE_LOG2 * g)) - 64'd1);
  end

  assign last   = lim[cks_i];
  assign tick_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + PRE_W'(1);
  end

  // R7
  pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= last));

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16,
  localparam int CNT_W = DIV_W + $clog2(OVS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_end_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = CNT_W'(div_i) * CNT_W'(OVS) + CNT_W'(OVS - 1);
  assign bit_end_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  // R7
  bit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= last));

endmodule

// File: rtl/uart_tx_frame_seq.sv
module uart_tx_frame_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bit_end_i,
  input  tx_mode_t          cfg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  output logic              tx_o,
  output logic              busy_o
);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              tx_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] mask;
  logic              par_bit;

  assign last_idx = IDX_W'(DATA_W - 1) - IDX_W'(cfg_i.len7);
  assign mask     = cfg_i.len7 ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
  assign par_bit  = (^(data_i & mask)) ^ cfg_i.par_odd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tx_q    <= 1'b1;
    end else if (start_i) begin
      state_q <= ST_START;
      idx_q   <= '0;
      tx_q    <= 1'b0;
    end else if (bit_end_i) begin
      unique case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          idx_q   <= '0;
          tx_q    <= data_i[0];
        end
        ST_DATA: begin
          if (idx_q == last_idx) begin
            idx_q <= '0;
            if (cfg_i.mp_en) begin
              state_q <= ST_EXTRA;
              tx_q    <= mpb_i;
            end else if (cfg_i.par_en) begin
              state_q <= ST_EXTRA;
              tx_q    <= par_bit;
            end else begin
              state_q <= ST_STOP;
              tx_q    <= 1'b1;
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            tx_q  <= data_i[idx_q + IDX_W'(1)];
          end
        end
        ST_EXTRA: begin
          state_q <= ST_STOP;
          idx_q   <= '0;
          tx_q    <= 1'b1;
        end
        ST_STOP: begin
          tx_q <= 1'b1;
          if (cfg_i.stop2 && (idx_q == '0)) begin
            idx_q <= IDX_W'(1);
          end else begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          tx_q    <= 1'b1;
        end
      endcase
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = (state_q != ST_IDLE);

  // R5
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !tx_o));

  // R7
  edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != $past(tx_o)) |-> ($past(bit_end_i) || $past(start_i)));

  // R6
  no_extra_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && bit_end_i && idx_q == last_idx && !cfg_i.mp_en && !cfg_i.par_en)
      |=> (state_q == ST_STOP));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int OVS      = 16,
  parameter int PRE_LOG2 = 2,
  localparam int MODE_W  = $bits(tx_mode_t),
  localparam int CKS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mpb_i,
  output logic              busy_o,
  output logic              tx_o
);

  tx_mode_t          cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] data_q;
  logic              mpb_q;
  logic              start;
  logic              tick;
  logic              bit_end;
  logic              busy;
  logic              unused_sync;

  assign start       = wr_i && !busy;
  assign unused_sync = cfg_q.sync_sel;  // async path only

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      div_q  <= '0;
      data_q <= '0;
      mpb_q  <= 1'b0;
    end else if (start) begin
      cfg_q  <= tx_mode_t'(mode_i);
      div_q  <= div_i;
      data_q <= wdata_i;
      mpb_q  <= mpb_i;
    end
  end

  uart_tx_prescaler #(
    .CKS_W   (CKS_W),
    .PRE_LOG2(PRE_LOG2)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .en_i  (busy),
    .cks_i (cfg_q.cks),
    .tick_o(tick)
  );

  uart_tx_bit_timer #(
    .DIV_W(DIV_W),
    .OVS  (OVS)
  ) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start),
    .en_i     (busy),
    .tick_i   (tick),
    .div_i    (div_q),
    .bit_end_o(bit_end)
  );

  uart_tx_frame_seq #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .bit_end_i(bit_end),
    .cfg_i    (cfg_q),
    .data_i   (data_q),
    .mpb_i    (mpb_q),
    .tx_o     (tx_o),
    .busy_o   (busy)
  );

  assign busy_o = busy;

  // R8 R9
  hold_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable({cfg_q, div_q, data_q, mpb_q}));

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode = '0;
  logic [7:0] div = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       mpb = 1'b0;
  logic       busy;
  logic       tx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_frame_tx dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .div_i  (div),
    .wr_i   (wr),
    .wdata_i(wdata),
    .mpb_i  (mpb),
    .busy_o (busy),
    .tx_o   (tx)
  );

  // {mode, div, data, mpb}
  localparam logic [24:0] VECS [10] = '{
    {8'h00, 8'h00, 8'hA5, 1'b0},  // 8N1
    {8'h40, 8'h00, 8'hD3, 1'b0},  // 7-bit, bit7 dropped
    {8'h20, 8'h00, 8'h07, 1'b0},  // even parity
    {8'h30, 8'h00, 8'h07, 1'b0},  // odd parity
    {8'h08, 8'h00, 8'h3C, 1'b0},  // two stops
    {8'h24, 8'h00, 8'h81, 1'b1},  // mp overrides parity
    {8'h01, 8'h01, 8'h5A, 1'b0},  // prescale /4, div 1
    {8'h62, 8'h00, 8'hFF, 1'b0},  // 7-bit even, /16
    {8'h8B, 8'h00, 8'h96, 1'b0},  // sync bit ignored, 2 stops, /64
    {8'h2C, 8'h00, 8'h6E, 1'b0}   // mp + parity + 2 stops, flag 0
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] m, input logic [7:0] d, input logic [7:0] dat,
                           input logic fb, input bit disturb, input string ftag);
    logic [11:0] bits;
    int          n;
    int          nd;
    bit          extra;
    int          bt;
    string       tag;
    nd    = m[6] ? 7 : 8;
    extra = m[2] || m[5];
    n     = 0;
    bits  = '0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nd; i++) bits[n++] = dat[i];
    if (m[2])      bits[n++] = fb;
    else if (m[5]) bits[n++] = (^(dat & (m[6] ? 8'h7F : 8'hFF))) ^ m[4];
    bits[n++] = 1'b1;
    if (m[3]) bits[n++] = 1'b1;
    bt = (1 << (2 * m[1:0])) * 16 * (d + 1);

    @(negedge clk);
    mode = m; div = d; wdata = dat; mpb = fb; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    repeat (bt / 2) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0)                    tag = "R2";
      else if (i <= nd)              tag = "R3";
      else if (extra && i == nd + 1) tag = m[2] ? "R6" : "R4";
      else                           tag = "R5";
      chk(tx === bits[i] && busy === 1'b1, {tag, "/", ftag}, $sformatf("bit %0d {busy,tx}", i),
          {6'd0, busy, tx}, {7'd0, bits[i]} | 8'h2);
      if (disturb && i == 2) begin
        wr = 1'b1; wdata = ~dat; mode = 8'h6B; div = 8'hFF; mpb = ~fb;
      end
      @(negedge clk);
      wr = 1'b0;
      repeat (bt - 1) @(posedge clk);
    end
    @(negedge clk);
    chk(busy === 1'b0 && tx === 1'b1, {"R5/", ftag}, "end {busy,tx}", {6'd0, busy, tx}, 8'h01);
    mode = '0; div = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx === 1'b1 && busy === 1'b0, "R1", "in reset {busy,tx}", {6'd0, busy, tx}, 8'h01);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1", "after reset {busy,tx}", {6'd0, busy, tx}, 8'h01);

    for (int v = 0; v < 10; v++) begin
      logic [24:0] e;
      e = VECS[v];
      run_frame(e[24:17], e[16:9], e[8:1], e[0], 1'b0,
                (v == 8) ? "R10" : ((v >= 6) ? "R7" : "vec"));
    end

    // R8 R9: inputs change and a second write arrive mid-frame
    run_frame(8'h20, 8'h00, 8'hC6, 1'b0, 1'b1, "R8/R9");

    // R1: reset in the middle of a frame
    @(negedge clk);
    mode = 8'h00; div = 8'h00; wdata = 8'h00; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy === 1'b1, "R1", "busy before reset", {7'd0, busy}, 8'h01);
    rst_n = 1'b0;
    #1;
    chk(tx === 1'b1 && busy === 1'b0, "R1", "mid-frame reset {busy,tx}", {6'd0, busy, tx}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1", "idle after reset {busy,tx}", {6'd0, busy, tx}, 8'h01);

    // frame after reset still correct
    run_frame(8'h30, 8'h00, 8'h01, 1'b0, 1'b0, "post");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule